// File: doc/BRIEF.md
# Two-Level Direct-Mapped Cache Tag Lookup

This block answers one question per request: where would a 32-bit byte address be found in a two-level cache? It holds a small first-level tag store and a larger second-level tag store, both direct-mapped, and stores only tags and valid bits. It tries the first level first. It consults the second level only when the first level misses.

Each lookup returns one of three codes: first-level hit, second-level hit, or miss. The tag stores are then refilled by a fixed rule:
- A second-level hit copies the line into the first level.
- A miss writes the line into both levels.

Three saturating counters tally the outcomes, and a clear input zeroes them. The block takes one request at a time over a valid/ready pair and returns a response pulse a fixed two cycles later. It is meant to sit beside a model of the data path that handles line data and memory timing.

Top module: `cache_lookup`

## Requirements
- R1: The line address is the byte address shifted right by 6 (64-byte lines). Any two byte addresses inside the same 64-byte line give the same result.
- R2: Each level is indexed by the low bits of the line address, modulo its line count. The stored tag is the whole line address, so two lines that share an index displace each other, even when they differ only in the top address bits.
- R3: When the first level holds a valid matching tag, the response code is 1 (first-level hit), whatever the second level holds.
- R4: A first-level miss with a valid match in the second level gives code 2. The line is then written into the first level, so the next access to it gives code 1.
- R5: A miss in both levels gives code 3. The line is then written into both levels.
- R6: resp_code is 1, 2 or 3 while resp_valid is high, and 0 while it is low.
- R7: A request is accepted in a cycle where req_valid and req_ready are both high (req_ready is high only when idle). req_ready is low in the two following cycles, resp_valid is high only in the second of them, and a request offered while busy is ignored.
- R8: Synchronous active-high reset clears every valid bit and every counter. After reset, req_ready is 1 and resp_valid is 0, and the first access to any line is a miss.
- R9: The first-level hit counter, second-level hit counter and miss counter each count their own code. The counter already shows the new value in the cycle where resp_valid is high.
- R10: Each counter saturates at its all-ones value (CNT_W bits wide, 32 by default).
- R11: cnt_clear high in a cycle sets all three counters to 0 in the next cycle. It wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Byte address of the request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_code | output | 2 | 1 first-level hit, 2 second-level hit, 3 miss, 0 when idle |
| cnt_clear | input | 1 | Zero all counters |
| cnt_l1_hit | output | CNT_W | First-level hit count |
| cnt_l2_hit | output | CNT_W | Second-level hit count |
| cnt_miss | output | CNT_W | Miss count |

## Verification
Directed sequences provoke each outcome in turn:
- a cold miss, followed by a same-line hit at a different byte offset;
- a first-level eviction by a line that shares only the first-level index, so the older line comes back as a second-level hit and then as a first-level hit;
- a line that differs only in the top address bit, showing that the whole line address is compared and that both levels can be displaced.

Random addresses drawn from a narrow pool of lines then mix all three outcomes with dense index conflicts. A small counter width in the bench drives the counters into saturation. Further directed runs cover:
- a request held valid during a busy lookup, which must not be taken;
- a clear that lands in the same cycle as an increment;
- a reset in mid-run, which must turn previously resident lines into misses.

// File: rtl/cache_lookup_pkg.sv
package cache_lookup_pkg;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 6;
    localparam int LINE_W = ADDR_W - OFS_W;

    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_L1_HIT = 2'd1,
        RES_L2_HIT = 2'd2,
        RES_MISS   = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    typedef struct packed {
        logic  valid;
        line_t tag;
    } tag_ent_t;

    function automatic line_t line_of(input logic [ADDR_W-1:0] a);
        return line_t'(a >> OFS_W);
    endfunction

    // first level is searched first; second level matters only on its miss
    function automatic res_e classify(input logic h1, input logic h2);
        if (h1)      return RES_L1_HIT;
        else if (h2) return RES_L2_HIT;
        else         return RES_MISS;
    endfunction

endpackage

// File: rtl/tag_array.sv
module tag_array
    import cache_lookup_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rd_en,
    input  line_t    rd_line,
    output tag_ent_t rd_ent,
    input  logic     wr_en,
    input  line_t    wr_line
);
    localparam int IDX_W = $clog2(LINES);

    function automatic logic [IDX_W-1:0] idx_of(input line_t l);
        return IDX_W'(l & line_t'(LINES - 1));
    endfunction

    line_t             tags [LINES];
    logic [LINES-1:0]  valid;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;

    assign rd_idx = idx_of(rd_line);
    assign wr_idx = idx_of(wr_line);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ent <= '0;
        end else if (rd_en) begin
            rd_ent <= '{valid: valid[rd_idx], tag: tags[rd_idx]};
        end
    end

    // R5
    install_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid[$past(wr_idx)]);

endmodule

// File: rtl/hit_counters.sv
module hit_counters
    import cache_lookup_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc_en,
    input  res_e                  code,
    output logic [2:0][CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar g = 0; g < 3; g++) begin : g_cnt
        logic bump;
        assign bump = inc_en && (code == res_e'(2'(g + 1)));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt[g] <= '0;
            end else if (bump && cnt[g] != CNT_MAX) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end

        // R10
        sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt[g] == CNT_MAX && !clr) |=> cnt[g] == CNT_MAX);

        // R11
        clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
            clr |=> cnt[g] == '0);

        // R9
        step_one_chk: assert property (@(posedge clk) disable iff (rst)
            !clr |=> (cnt[g] == $past(cnt[g]) || cnt[g] == $past(cnt[g]) + 1'b1));
    end

endmodule

// File: rtl/cache_lookup.sv
module cache_lookup
    import cache_lookup_pkg::*;
#(
    parameter int L1_LINES = 16,
    parameter int L2_LINES = 64,
    parameter int CNT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    input  logic             cnt_clear,
    output logic [CNT_W-1:0] cnt_l1_hit,
    output logic [CNT_W-1:0] cnt_l2_hit,
    output logic [CNT_W-1:0] cnt_miss
);
    state_e   state;
    line_t    line_q;
    res_e     code_q;
    res_e     code_now;
    tag_ent_t ent1, ent2;
    logic     accept, looking, hit1, hit2, wr1, wr2;
    line_t    req_line;
    logic [2:0][CNT_W-1:0] cnts;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign looking   = (state == ST_LOOK);
    assign req_line  = line_of(req_addr);

    assign hit1     = ent1.valid && (ent1.tag == line_q);
    assign hit2     = ent2.valid && (ent2.tag == line_q);
    assign code_now = classify(hit1, hit2);
    assign wr1      = looking && !hit1;
    assign wr2      = looking && !hit1 && !hit2;

    tag_array #(.LINES(L1_LINES)) u_l1 (
        .clk(clk), .rst(rst),
        .rd_en(accept), .rd_line(req_line), .rd_ent(ent1),
        .wr_en(wr1), .wr_line(line_q)
    );

    tag_array #(.LINES(L2_LINES)) u_l2 (
        .clk(clk), .rst(rst),
        .rd_en(accept), .rd_line(req_line), .rd_ent(ent2),
        .wr_en(wr2), .wr_line(line_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            line_q <= '0;
            code_q <= RES_NONE;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_LOOK;
                    line_q <= req_line;
                end
                ST_LOOK: begin
                    state  <= ST_RESP;
                    code_q <= code_now;
                end
                default: begin
                    state  <= ST_IDLE;
                    code_q <= RES_NONE;
                end
            endcase
        end
    end

    assign resp_valid = (state == ST_RESP);
    assign resp_code  = resp_valid ? code_q : RES_NONE;

    hit_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clear),
        .inc_en(looking), .code(code_now), .cnt(cnts)
    );

    assign cnt_l1_hit = cnts[0];
    assign cnt_l2_hit = cnts[1];
    assign cnt_miss   = cnts[2];

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!req_ready && !resp_valid));

    // R7
    resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> ##1 resp_valid);

    // R7
    resp_single_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

    // R6
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> resp_code != 2'd0);

    // R4
    promote_chk: assert property (@(posedge clk) disable iff (rst)
        (looking && !hit1 && hit2) |-> (wr1 && !wr2));

endmodule

// File: tb/sim_cache_lookup.sv
module sim_cache_lookup;

    localparam int L1N  = 16;
    localparam int L2N  = 64;
    localparam int CW   = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic          resp_valid;
    logic [1:0]    resp_code;
    logic          cnt_clear = 1'b0;
    logic [CW-1:0] cnt_l1_hit, cnt_l2_hit, cnt_miss;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [25:0] m1_tag [L1N];
    bit          m1_v   [L1N];
    logic [25:0] m2_tag [L2N];
    bit          m2_v   [L2N];
    int          e_cnt  [3];

    always #2 clk = ~clk;

    cache_lookup #(.L1_LINES(L1N), .L2_LINES(L2N), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .cnt_clear(cnt_clear),
        .cnt_l1_hit(cnt_l1_hit), .cnt_l2_hit(cnt_l2_hit), .cnt_miss(cnt_miss)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < L1N; i++) m1_v[i] = 1'b0;
        for (int i = 0; i < L2N; i++) m2_v[i] = 1'b0;
        for (int i = 0; i < 3; i++) e_cnt[i] = 0;
    endtask

    task automatic model_access(input logic [31:0] a, output logic [1:0] code);
        logic [25:0] ln = a[31:6];
        int i1 = int'(ln % L1N);
        int i2 = int'(ln % L2N);
        if (m1_v[i1] && m1_tag[i1] == ln) begin
            code = 2'd1;
        end else if (m2_v[i2] && m2_tag[i2] == ln) begin
            code = 2'd2;
            m1_v[i1] = 1'b1; m1_tag[i1] = ln;
        end else begin
            code = 2'd3;
            m1_v[i1] = 1'b1; m1_tag[i1] = ln;
            m2_v[i2] = 1'b1; m2_tag[i2] = ln;
        end
    endtask

    task automatic chk_counts(input string rq);
        chk({rq, " l1 count"}, 32'(cnt_l1_hit), 32'(e_cnt[0]));
        chk({rq, " l2 count"}, 32'(cnt_l2_hit), 32'(e_cnt[1]));
        chk({rq, " miss count"}, 32'(cnt_miss), 32'(e_cnt[2]));
    endtask

    // called at a falling edge with the block idle
    task automatic do_req(input logic [31:0] a, input bit clr_look, input bit hold_busy);
        logic [1:0] ec;
        string tg;
        model_access(a, ec);
        tg = (ec == 2'd1) ? "R3 l1 hit" : (ec == 2'd2) ? "R4 l2 hit" : "R5 miss";
        if (clr_look) begin
            for (int i = 0; i < 3; i++) e_cnt[i] = 0;
        end else if (e_cnt[ec-1] < CMAX) begin
            e_cnt[ec-1]++;
        end
        req_valid = 1'b1;
        req_addr  = a;
        chk("R7 ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        if (hold_busy) req_addr = 32'hFFFF_FFC0;
        else req_valid = 1'b0;
        if (clr_look) cnt_clear = 1'b1;
        chk("R7 busy after accept", 32'(req_ready), 32'd0);
        chk("R7 no early response", 32'(resp_valid), 32'd0);
        @(negedge clk);
        cnt_clear = 1'b0;
        chk("R7 response strobe", 32'(resp_valid), 32'd1);
        chk("R7 busy in response", 32'(req_ready), 32'd0);
        chk(tg, 32'(resp_code), 32'(ec));
        chk_counts(clr_look ? "R11" : "R9 R10");
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 idle again", 32'(req_ready), 32'd1);
        chk("R6 code zero when idle", 32'(resp_code), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        int s;
        model_reset();
        s = int'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk("R8 ready after reset", 32'(req_ready), 32'd1);
        chk("R8 no response after reset", 32'(resp_valid), 32'd0);
        chk("R6 code zero after reset", 32'(resp_code), 32'd0);
        chk_counts("R8");

        // R1 same line, different offset
        do_req(32'h0000_1040, 1'b0, 1'b0);
        do_req(32'h0000_107F, 1'b0, 1'b0);
        // R2 first-level conflict, then R4 promotion
        do_req(32'h0000_1440, 1'b0, 1'b0);
        do_req(32'h0000_1048, 1'b0, 1'b0);
        do_req(32'h0000_1050, 1'b0, 1'b0);
        // R2 full tag: differs only in top bit, same indices in both levels
        do_req(32'h8000_1040, 1'b0, 1'b0);
        do_req(32'h0000_1040, 1'b0, 1'b0);
        // R7 request held valid while busy is ignored; its line stays absent
        do_req(32'h0000_2000, 1'b0, 1'b1);
        do_req(32'hFFFF_FFC0, 1'b0, 1'b0);

        // random mix with dense index conflicts, saturating counters (R10)
        for (int n = 0; n < 300; n++) begin
            a = (($urandom % 160) << 6) | ($urandom % 64);
            if ($urandom % 8 == 0) a = a | 32'h4000_0000;
            do_req(a, 1'b0, 1'b0);
        end

        // R11 clear while idle
        cnt_clear = 1'b1;
        @(negedge clk);
        cnt_clear = 1'b0;
        for (int i = 0; i < 3; i++) e_cnt[i] = 0;
        chk_counts("R11 idle clear");

        // R11 clear coinciding with increments
        for (int n = 0; n < 200; n++) begin
            a = (($urandom % 96) << 6) | ($urandom % 64);
            do_req(a, ($urandom % 10 == 0), 1'b0);
        end

        // R8 reset mid-run: a resident line becomes a miss
        do_req(32'h0000_3000, 1'b0, 1'b0);
        do_req(32'h0000_3000, 1'b0, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk_counts("R8 mid-run reset");
        do_req(32'h0000_3000, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule